// File: doc/BRIEF.md
# Coherent Read Phase Tracker for One Cache Line

This block watches a single coherent read as it crosses a cluster-side bridge and checks that its steps come in the required order. There are five event streams, each a one-cycle strobe with its own fields. The cluster issues a read request. The bridge forwards that request toward the client interconnect. The interconnect returns a fill/ownership response. The cluster side then sees read data beats, and finally a read acknowledge. The tracker steps through one phase per expected event and returns to idle once the acknowledge arrives.

The first cluster read request seen while idle starts a transaction. Its cache-line tag (the address with the in-line offset dropped) and its read ID are latched and held until the tracker is idle again. After that, only events that carry the latched line or the latched ID take part in tracking, and all other traffic passes unseen. Three sticky flags record misuse. One flags a second request to the same line while a transaction is open. One flags read data that comes back ahead of its fill response. One flags any other expected-type event that arrives in the wrong phase. The phase is exported so that neighbouring checkers or debug logic can follow progress.

Top module: `coh_rd_tracker`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising clock edge sets `phase` to 0 (idle), drives `busy` low and clears all three error flags. Phase codes: 0 idle, 1 awaiting forward request, 2 awaiting fill, 3 awaiting read data, 4 awaiting acknowledge.
- R2: In phase 0, a cluster read request of any address moves the phase to 1 on the next edge. It latches the line tag, which is address bits [ADDR_W-1:LINE_OFS] (LINE_OFS = 6 by default), and it latches the request ID.
- R3: In phase 1, a forwarded request whose line tag equals the latched tag moves the phase to 2. Differences in address bits below LINE_OFS do not matter.
- R4: In phase 2, a fill response to the latched line moves the phase to 3.
- R5: In phase 3, read data with the latched ID and the last-beat marker high moves the phase to 4. A beat with the marker low leaves the phase at 3.
- R6: In phase 4, an acknowledge with the latched ID returns the phase to 0.
- R7: A cluster read request to the latched line while `phase` is not 0 sets `err_overlap` and does not change the phase.
- R8: Read data with the latched ID in phase 1 or 2 sets `err_order` and does not change the phase.
- R9: A matching forward request, fill response or acknowledge in a non-idle phase other than the one that expects it sets `err_proto`. Matching read data in phase 4 also sets `err_proto`. In either case the phase does not change.
- R10: Events for other lines or other IDs have no effect on the phase or the error flags. In phase 0 every stream except the cluster request is ignored.
- R11: The error flags stay set until reset. `busy` is high exactly when `phase` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_req_vld | input | 1 | Cluster read request strobe |
| cl_req_addr | input | ADDR_W | Cluster read request address |
| cl_req_id | input | ID_W | Cluster read request ID |
| fwd_req_vld | input | 1 | Forwarded interconnect request strobe |
| fwd_req_addr | input | ADDR_W | Forwarded request address |
| fill_rsp_vld | input | 1 | Fill/ownership response strobe |
| fill_rsp_addr | input | ADDR_W | Fill response address |
| rd_dat_vld | input | 1 | Cluster read data beat strobe |
| rd_dat_id | input | ID_W | Read data ID |
| rd_dat_last | input | 1 | Last-beat marker |
| rd_ack_vld | input | 1 | Cluster read acknowledge strobe |
| rd_ack_id | input | ID_W | Acknowledge ID |
| phase | output | 3 | Current phase code |
| busy | output | 1 | Transaction open |
| err_overlap | output | 1 | Sticky: second request to an open line |
| err_order | output | 1 | Sticky: data ahead of fill response |
| err_proto | output | 1 | Sticky: event in a wrong phase |

## Verification
The phase and the flags are registered, so a wrong transition or a wrong latched tag or ID shows at the ports one edge after the event that exposes it. If the latched tag or ID is corrupted, the next event for the real line is ignored, and `phase` stalls where the model expects it to move. If the latched value matches traffic it should not, `phase` moves or an error flag rises where the model expects nothing. A bad reset or a flag that loses its sticky behaviour also shows up as a difference in the per-cycle comparison.

// File: rtl/coh_trk_pkg.sv
package coh_trk_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_WAIT_FWD  = 3'd1,
        PH_WAIT_FILL = 3'd2,
        PH_WAIT_DATA = 3'd3,
        PH_WAIT_ACK  = 3'd4
    } phase_e;

    // Per-cycle match flags: each is an event that refers to the open transaction.
    typedef struct packed {
        logic clreq;
        logic fwd;
        logic fill;
        logic dat;
        logic ack;
    } hit_t;

    typedef struct packed {
        logic overlap;
        logic order;
        logic proto;
    } err_t;

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_IDLE:      phase_after = PH_WAIT_FWD;
            PH_WAIT_FWD:  phase_after = PH_WAIT_FILL;
            PH_WAIT_FILL: phase_after = PH_WAIT_DATA;
            PH_WAIT_DATA: phase_after = PH_WAIT_ACK;
            default:      phase_after = PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/trk_match.sv
module trk_match
    import coh_trk_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int ID_W  = 4
) (
    input  logic             open_q,
    input  logic [TAG_W-1:0] cap_tag,
    input  logic [ID_W-1:0]  cap_id,
    input  logic             cl_req_vld,
    input  logic [TAG_W-1:0] cl_req_tag,
    input  logic             fwd_vld,
    input  logic [TAG_W-1:0] fwd_tag,
    input  logic             fill_vld,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dat_vld,
    input  logic [ID_W-1:0]  dat_id,
    input  logic             ack_vld,
    input  logic [ID_W-1:0]  ack_id,
    output hit_t             hits
);
    always_comb begin
        hits.clreq = open_q && cl_req_vld && (cl_req_tag == cap_tag);
        hits.fwd   = open_q && fwd_vld    && (fwd_tag    == cap_tag);
        hits.fill  = open_q && fill_vld   && (fill_tag   == cap_tag);
        hits.dat   = open_q && dat_vld    && (dat_id     == cap_id);
        hits.ack   = open_q && ack_vld    && (ack_id     == cap_id);
    end
endmodule

// File: rtl/trk_phase_fsm.sv
module trk_phase_fsm
    import coh_trk_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cl_req_vld,
    input  logic [TAG_W-1:0] cl_req_tag,
    input  logic [ID_W-1:0]  cl_req_id,
    input  hit_t             hits,
    input  logic             dat_last,
    output phase_e           phase_q,
    output logic [TAG_W-1:0] cap_tag,
    output logic [ID_W-1:0]  cap_id
);
    logic advance;

    always_comb begin
        case (phase_q)
            PH_IDLE:      advance = cl_req_vld;
            PH_WAIT_FWD:  advance = hits.fwd;
            PH_WAIT_FILL: advance = hits.fill;
            PH_WAIT_DATA: advance = hits.dat && dat_last;
            PH_WAIT_ACK:  advance = hits.ack;
            default:      advance = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cap_tag <= '0;
            cap_id  <= '0;
        end else begin
            if (advance) begin
                phase_q <= phase_after(phase_q);
            end
            if ((phase_q == PH_IDLE) && cl_req_vld) begin
                cap_tag <= cl_req_tag;
                cap_id  <= cl_req_id;
            end
        end
    end
endmodule

// File: rtl/trk_err_flags.sv
module trk_err_flags
    import coh_trk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_q,
    input  hit_t   hits,
    output err_t   err_q
);
    err_t set_now;

    always_comb begin
        set_now.overlap = hits.clreq;
        set_now.order   = hits.dat && ((phase_q == PH_WAIT_FWD) || (phase_q == PH_WAIT_FILL));
        set_now.proto   = (hits.fwd  && (phase_q != PH_WAIT_FWD))
                        | (hits.fill && (phase_q != PH_WAIT_FILL))
                        | (hits.ack  && (phase_q != PH_WAIT_ACK))
                        | (hits.dat  && (phase_q == PH_WAIT_ACK));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | set_now;
        end
    end
endmodule

// File: rtl/coh_rd_tracker.sv
module coh_rd_tracker
    import coh_trk_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ID_W     = 4,
    parameter int LINE_OFS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cl_req_vld,
    input  logic [ADDR_W-1:0] cl_req_addr,
    input  logic [ID_W-1:0]   cl_req_id,
    input  logic              fwd_req_vld,
    input  logic [ADDR_W-1:0] fwd_req_addr,
    input  logic              fill_rsp_vld,
    input  logic [ADDR_W-1:0] fill_rsp_addr,
    input  logic              rd_dat_vld,
    input  logic [ID_W-1:0]   rd_dat_id,
    input  logic              rd_dat_last,
    input  logic              rd_ack_vld,
    input  logic [ID_W-1:0]   rd_ack_id,
    output logic [2:0]        phase,
    output logic              busy,
    output logic              err_overlap,
    output logic              err_order,
    output logic              err_proto
);
    localparam int TAG_W = ADDR_W - LINE_OFS;

    phase_e           phase_q;
    logic [TAG_W-1:0] cap_tag;
    logic [ID_W-1:0]  cap_id;
    hit_t             hits;
    err_t             err_q;
    logic             open_q;

    // Offset bits inside a line never take part in matching.
    logic unused_offsets;
    assign unused_offsets = ^{cl_req_addr[LINE_OFS-1:0],
                              fwd_req_addr[LINE_OFS-1:0],
                              fill_rsp_addr[LINE_OFS-1:0]};

    assign open_q = (phase_q != PH_IDLE);

    trk_match #(.TAG_W(TAG_W), .ID_W(ID_W)) u_match (
        .open_q     (open_q),
        .cap_tag    (cap_tag),
        .cap_id     (cap_id),
        .cl_req_vld (cl_req_vld),
        .cl_req_tag (cl_req_addr[ADDR_W-1:LINE_OFS]),
        .fwd_vld    (fwd_req_vld),
        .fwd_tag    (fwd_req_addr[ADDR_W-1:LINE_OFS]),
        .fill_vld   (fill_rsp_vld),
        .fill_tag   (fill_rsp_addr[ADDR_W-1:LINE_OFS]),
        .dat_vld    (rd_dat_vld),
        .dat_id     (rd_dat_id),
        .ack_vld    (rd_ack_vld),
        .ack_id     (rd_ack_id),
        .hits       (hits)
    );

    trk_phase_fsm #(.TAG_W(TAG_W), .ID_W(ID_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cl_req_vld (cl_req_vld),
        .cl_req_tag (cl_req_addr[ADDR_W-1:LINE_OFS]),
        .cl_req_id  (cl_req_id),
        .hits       (hits),
        .dat_last   (rd_dat_last),
        .phase_q    (phase_q),
        .cap_tag    (cap_tag),
        .cap_id     (cap_id)
    );

    trk_err_flags u_err (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .hits    (hits),
        .err_q   (err_q)
    );

    assign phase       = phase_q;
    assign busy        = open_q;
    assign err_overlap = err_q.overlap;
    assign err_order   = err_q.order;
    assign err_proto   = err_q.proto;
endmodule

// File: rtl/coh_trk_chk.sv
module coh_trk_chk (
    input logic       clk,
    input logic       rst,
    input logic       cl_req_vld,
    input logic       rd_dat_vld,
    input logic [2:0] phase,
    input logic       busy,
    input logic       err_overlap,
    input logic       err_order,
    input logic       err_proto
);
    logic rst_q = 1'b1;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_state_R1: assert (phase == 3'd0 && !busy && !err_overlap && !err_order && !err_proto)
                else $error("reset state wrong");
        end
    end

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst || rst_q)
        (phase == 3'd0 && cl_req_vld) |=> phase == 3'd1);

    // R5: any change from a non-idle phase goes to the next step of the sequence
    assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst || rst_q)
        ($past(phase) != 3'd0 && phase != $past(phase)) |->
            phase == (($past(phase) == 3'd4) ? 3'd0 : $past(phase) + 3'd1));

    assert_overlap_cause_R7: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(err_overlap) |-> ($past(cl_req_vld) && $past(busy)));

    assert_order_cause_R8: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(err_order) |-> ($past(rd_dat_vld) && ($past(phase) == 3'd1 || $past(phase) == 3'd2)));

    assert_proto_busy_R9: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(err_proto) |-> $past(busy));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst || rst_q)
        (err_overlap || err_order || err_proto) |=>
            ((err_overlap || !$past(err_overlap)) && (err_order || !$past(err_order))
             && (err_proto || !$past(err_proto))));
endmodule

bind coh_rd_tracker coh_trk_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cl_req_vld  (cl_req_vld),
    .rd_dat_vld  (rd_dat_vld),
    .phase       (phase),
    .busy        (busy),
    .err_overlap (err_overlap),
    .err_order   (err_order),
    .err_proto   (err_proto)
);

// File: tb/test_coh_rd_tracker.sv
module test_coh_rd_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int IW  = 4;
    localparam int OFS = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cl_req_vld = 0;
    logic [AW-1:0] cl_req_addr = '0;
    logic [IW-1:0] cl_req_id = '0;
    logic          fwd_req_vld = 0;
    logic [AW-1:0] fwd_req_addr = '0;
    logic          fill_rsp_vld = 0;
    logic [AW-1:0] fill_rsp_addr = '0;
    logic          rd_dat_vld = 0;
    logic [IW-1:0] rd_dat_id = '0;
    logic          rd_dat_last = 0;
    logic          rd_ack_vld = 0;
    logic [IW-1:0] rd_ack_id = '0;
    logic [2:0]    phase;
    logic          busy, err_overlap, err_order, err_proto;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_rd_tracker #(.ADDR_W(AW), .ID_W(IW), .LINE_OFS(OFS)) i_coh_rd_tracker (.*);

    // Behavioural reference model
    int ref_ph = 0;
    int ref_tag = 0;
    int ref_id = 0;
    bit ref_ov = 0, ref_ord = 0, ref_pr = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            ref_ph = 0; ref_tag = 0; ref_id = 0;
            ref_ov = 0; ref_ord = 0; ref_pr = 0;
        end else if (ref_ph == 0) begin
            if (cl_req_vld) begin
                ref_ph  = 1;
                ref_tag = int'(cl_req_addr >> OFS);
                ref_id  = int'(cl_req_id);
            end
        end else begin
            automatic int nxt = ref_ph;
            if (cl_req_vld && int'(cl_req_addr >> OFS) == ref_tag) ref_ov = 1;
            if (fwd_req_vld && int'(fwd_req_addr >> OFS) == ref_tag) begin
                if (ref_ph == 1) nxt = 2; else ref_pr = 1;
            end
            if (fill_rsp_vld && int'(fill_rsp_addr >> OFS) == ref_tag) begin
                if (ref_ph == 2) nxt = 3; else ref_pr = 1;
            end
            if (rd_dat_vld && int'(rd_dat_id) == ref_id) begin
                if (ref_ph == 1 || ref_ph == 2) ref_ord = 1;
                else if (ref_ph == 4) ref_pr = 1;
                else if (rd_dat_last) nxt = 4;
            end
            if (rd_ack_vld && int'(rd_ack_id) == ref_id) begin
                if (ref_ph == 4) nxt = 0; else ref_pr = 1;
            end
            ref_ph = nxt;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("model phase R1", int'(phase), ref_ph);
            chk("model busy R11", int'(busy), int'(ref_ph != 0));
            chk("model overlap R7", int'(err_overlap), int'(ref_ov));
            chk("model order R8", int'(err_order), int'(ref_ord));
            chk("model proto R9", int'(err_proto), int'(ref_pr));
        end
    end

    task automatic send_req(logic [AW-1:0] a, logic [IW-1:0] id);
        @(negedge clk); cl_req_vld = 1; cl_req_addr = a; cl_req_id = id;
        @(negedge clk); cl_req_vld = 0;
    endtask
    task automatic send_fwd(logic [AW-1:0] a);
        @(negedge clk); fwd_req_vld = 1; fwd_req_addr = a;
        @(negedge clk); fwd_req_vld = 0;
    endtask
    task automatic send_fill(logic [AW-1:0] a);
        @(negedge clk); fill_rsp_vld = 1; fill_rsp_addr = a;
        @(negedge clk); fill_rsp_vld = 0;
    endtask
    task automatic send_dat(logic [IW-1:0] id, logic last);
        @(negedge clk); rd_dat_vld = 1; rd_dat_id = id; rd_dat_last = last;
        @(negedge clk); rd_dat_vld = 0; rd_dat_last = 0;
    endtask
    task automatic send_ack(logic [IW-1:0] id);
        @(negedge clk); rd_ack_vld = 1; rd_ack_id = id;
        @(negedge clk); rd_ack_vld = 0;
    endtask
    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    localparam logic [AW-1:0] LA = 32'h0000_1240;
    localparam logic [AW-1:0] LB = 32'h0000_8800;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 phase after reset", int'(phase), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 flags after reset", int'({err_overlap, err_order, err_proto}), 0);

        // Full clean transaction
        send_req(LA, 4'd3);
        chk("R2 idle to wait-forward", int'(phase), 1);
        chk("R11 busy when open", int'(busy), 1);
        send_fwd(LA ^ 32'h0000_1000);
        chk("R10 other line forward ignored", int'(phase), 1);
        send_dat(4'd5, 1'b1);
        chk("R10 other id data ignored", int'(err_order), 0);
        send_fwd(LA + 32'h3c);
        chk("R3 same line, other offset", int'(phase), 2);
        send_fill(LA);
        chk("R4 fill to wait-data", int'(phase), 3);
        send_dat(4'd3, 1'b0);
        chk("R5 non-last beat holds", int'(phase), 3);
        send_dat(4'd3, 1'b1);
        chk("R5 last beat to wait-ack", int'(phase), 4);
        send_ack(4'd3);
        chk("R6 ack returns idle", int'(phase), 0);
        chk("R9 no proto error on clean flow", int'(err_proto), 0);
        send_fill(LA);
        chk("R10 idle ignores fill", int'(phase), 0);
        chk("R10 idle fill sets no flag", int'(err_proto), 0);

        // Error cases
        send_req(LA, 4'd2);
        send_req(LA + 32'h4, 4'd2);
        chk("R7 overlap flag", int'(err_overlap), 1);
        chk("R7 phase unchanged", int'(phase), 1);
        send_dat(4'd2, 1'b1);
        chk("R8 early data flag", int'(err_order), 1);
        chk("R8 phase unchanged", int'(phase), 1);
        send_ack(4'd2);
        chk("R9 ack in wrong phase", int'(err_proto), 1);
        chk("R9 phase unchanged", int'(phase), 1);
        send_fwd(LA); send_fill(LA); send_dat(4'd2, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 flags sticky", int'({err_overlap, err_order, err_proto}), 7);
        chk("R5 reached wait-ack", int'(phase), 4);
        do_reset();
        chk("R1 reset clears", int'({phase, err_overlap, err_order, err_proto}), 0);

        // Captured ID and data in acknowledge phase
        send_req(LB, 4'd7);
        send_ack(4'd3);
        chk("R10 other id ack ignored", int'(err_proto), 0);
        send_fwd(LB); send_fill(LB + 32'h10); send_dat(4'd7, 1'b1);
        chk("R5 second flow wait-ack", int'(phase), 4);
        send_dat(4'd7, 1'b1);
        chk("R9 data in ack phase", int'(err_proto), 1);
        chk("R9 phase held", int'(phase), 4);
        send_ack(4'd7);
        chk("R6 back to idle", int'(phase), 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule